// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences a small processor system into and out of its low-power states. The core issues a one-cycle sleep request tagged as a wait-for-interrupt or wait-for-event entry. The request is resolved against three control bits: deep, power-down and low-power-regulator. The result is one of three states. Sleep only halts the processor clock. Stop halts every core-domain clock and the oscillators while keeping state. Standby removes core-domain power. For each state the block drives the clock gates, the oscillator enables, the regulator mode and the core power enable.

Every state has its own set of wake sources. Sleep and Stop wake on a pending interrupt or on an event, depending on how they were entered. Optionally, an interrupt that newly becomes pending also counts as an event. Standby wakes only on a wake-pin rising edge, an alarm rising edge, an external reset or a watchdog reset. Stop and Standby exits both wait out a programmable startup delay. A Stop exit then pulses a request to fall back to the internal RC clock. A Standby exit pulses a restart instead. A sleep-on-exit control sends the system back to Sleep when the core signals a return from handler to thread mode.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After synchronous reset the block is in Run: `mode_o`=0, both clock gates open, `osc_en`=3'b111, `reg_lp`=0, `core_pwr_en`=1, and `restart` and `force_hsi` are 0.
- R2: In Run, a `sleep_req` with `deep_sel`=0 enters Sleep (`mode_o`=1) on the next edge. In Sleep, `cpu_clk_en`=0 while `periph_clk_en`=1 and `osc_en`=3'b111 stay on.
- R3: A `sleep_req` with `deep_sel`=1 and `pdown_sel`=0 enters Stop (`mode_o`=2). In Stop both clock gates are 0, `osc_en`=3'b000, `core_pwr_en`=1, and `reg_lp` equals the `lpreg_sel` value latched at entry.
- R4: A `sleep_req` with `deep_sel`=1 and `pdown_sel`=1 enters Standby (`mode_o`=3). All gates, the oscillators, `reg_lp` and `core_pwr_en` are 0.
- R5: A Sleep or Stop entered with `req_kind`=0 (wait-for-interrupt) leaves on the first edge that sees `irq_pending`=1. An `evt_in` pulse has no effect on it.
- R6: A Sleep or Stop entered with `req_kind`=1 (wait-for-event) leaves on the first edge that sees `evt_in`=1. A pending interrupt alone has no effect when `sev_on_pend`=0.
- R7: With `sev_on_pend`=1, a wait-for-event Sleep or Stop also leaves when `irq_pending` rises from 0 to 1. An interrupt that was already pending at entry does not wake it.
- R8: Standby leaves only on a qualified wake-pin rise, an `alarm_in` rise, `ext_rst` or `wdt_rst`. Interrupts and events are ignored there.
- R9: `wkpin_async` passes through a two-flop synchronizer, so a rise applied before an edge is acted on at the third edge. A rise is ignored while `wkpin_en`=0.
- R10: Sleep returns to Run on the edge that sees its wake source. Stop and Standby first enter a startup wait of D+1 cycles, during which `mode_o` keeps the departed mode and `osc_en`=3'b001. D is `dly_main` for a Stop exit with the main regulator, and `dly_lp` for a Stop exit with the low-power regulator or for any Standby exit.
- R11: On the edge that ends the startup wait, `force_hsi` pulses for one cycle after a Stop exit, and `restart` pulses for one cycle after a Standby exit. Never both.
- R12: In Run with `sleep_on_exit`=1, a `handler_ret` pulse enters Sleep as a wait-for-interrupt entry. With `sleep_on_exit`=0 it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| req_kind | input | 1 | 0 = wait-for-interrupt entry, 1 = wait-for-event entry |
| deep_sel | input | 1 | Deep low-power select |
| pdown_sel | input | 1 | Power-down select (Standby when deep) |
| lpreg_sel | input | 1 | Low-power regulator select for Stop |
| sev_on_pend | input | 1 | Newly pending interrupt counts as an event |
| sleep_on_exit | input | 1 | Re-enter Sleep on handler return |
| handler_ret | input | 1 | One-cycle handler-to-thread return pulse |
| irq_pending | input | 1 | Any enabled interrupt pending (level) |
| evt_in | input | 1 | Wake event pulse |
| wkpin_async | input | 1 | Asynchronous wake pin |
| wkpin_en | input | 1 | Wake-pin enable |
| alarm_in | input | 1 | Alarm signal (rise wakes Standby) |
| ext_rst | input | 1 | External reset request |
| wdt_rst | input | 1 | Watchdog reset request |
| dly_main | input | DLY_W | Startup delay with main regulator |
| dly_lp | input | DLY_W | Startup delay with low-power regulator / Standby |
| cpu_clk_en | output | 1 | Processor clock gate |
| periph_clk_en | output | 1 | Peripheral clock gate |
| osc_en | output | 3 | Oscillator enables: [0] internal RC, [1] crystal, [2] PLL |
| reg_lp | output | 1 | Regulator in low-power mode |
| core_pwr_en | output | 1 | Core-domain power enable |
| restart | output | 1 | Restart pulse after Standby exit |
| force_hsi | output | 1 | Select internal RC as system clock after Stop exit |
| mode_o | output | 2 | Run=0, Sleep=1, Stop=2, Standby=3 |

## Verification
Several properties are checked on every cycle: the gating pattern that each reported mode implies, core power being absent only in Standby, the exclusivity and single-cycle width of the restart and clock-fallback pulses, and the presence of a legal wake cause on every exit from Sleep or Standby. The bench scenarios cover the things that depend on entry history. These are the wake source chosen by the entry kind, the pending-at-entry case for the event-on-pend option, the synchronizer latency, and the exact startup-wait length for each regulator choice, all of which need a known stimulus sequence and cycle counting.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_STOP  = 2'd2,
        MODE_STBY  = 2'd3
    } pmode_e;

    typedef enum logic [2:0] {
        S_RUN, S_SLEEP, S_STOP, S_STBY, S_WAKE
    } pstate_e;

    localparam int OSC_N = 3;
    localparam logic [OSC_N-1:0] OSC_ALL = 3'b111;
    localparam logic [OSC_N-1:0] OSC_RC  = 3'b001;
    localparam logic [OSC_N-1:0] OSC_OFF = 3'b000;

    typedef struct packed {
        logic             cpu_clk;
        logic             per_clk;
        logic [OSC_N-1:0] osc;
        logic             reg_lp;
        logic             core_pwr;
    } pgate_t;

    function automatic pstate_e target_state(input logic deep, input logic pdown);
        if (!deep)      return S_SLEEP;
        else if (pdown) return S_STBY;
        else            return S_STOP;
    endfunction

    function automatic pgate_t gates_for(input pstate_e st, input logic lp);
        pgate_t g;
        case (st)
            S_SLEEP: g = '{cpu_clk:1'b0, per_clk:1'b1, osc:OSC_ALL, reg_lp:1'b0, core_pwr:1'b1};
            S_STOP:  g = '{cpu_clk:1'b0, per_clk:1'b0, osc:OSC_OFF, reg_lp:lp,   core_pwr:1'b1};
            S_STBY:  g = '{cpu_clk:1'b0, per_clk:1'b0, osc:OSC_OFF, reg_lp:1'b0, core_pwr:1'b0};
            S_WAKE:  g = '{cpu_clk:1'b0, per_clk:1'b0, osc:OSC_RC,  reg_lp:1'b0, core_pwr:1'b1};
            default: g = '{cpu_clk:1'b1, per_clk:1'b1, osc:OSC_ALL, reg_lp:1'b0, core_pwr:1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    input  logic en,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], d};
    end

    assign rise = en & chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual (
    input  logic clk,
    input  logic rst,
    input  logic kind_evt,
    input  logic sev_on_pend,
    input  logic irq_pending,
    input  logic evt_in,
    input  logic pin_rise,
    input  logic alarm_in,
    input  logic ext_rst,
    input  logic wdt_rst,
    output logic light_wake,
    output logic stby_wake
);
    logic irq_q;
    logic alarm_q;
    logic irq_new;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            alarm_q <= 1'b0;
        end else begin
            irq_q   <= irq_pending;
            alarm_q <= alarm_in;
        end
    end

    assign irq_new    = irq_pending & ~irq_q;
    assign light_wake = kind_evt ? (evt_in | (sev_on_pend & irq_new)) : irq_pending;
    assign stby_wake  = pin_rise | (alarm_in & ~alarm_q) | ext_rst | wdt_rst;
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int DLY_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             req_kind,
    input  logic             deep_sel,
    input  logic             pdown_sel,
    input  logic             lpreg_sel,
    input  logic             sev_on_pend,
    input  logic             sleep_on_exit,
    input  logic             handler_ret,
    input  logic             irq_pending,
    input  logic             evt_in,
    input  logic             wkpin_async,
    input  logic             wkpin_en,
    input  logic             alarm_in,
    input  logic             ext_rst,
    input  logic             wdt_rst,
    input  logic [DLY_W-1:0] dly_main,
    input  logic [DLY_W-1:0] dly_lp,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic [OSC_N-1:0] osc_en,
    output logic             reg_lp,
    output logic             core_pwr_en,
    output logic             restart,
    output logic             force_hsi,
    output logic [1:0]       mode_o
);
    pstate_e    state_q, state_d;
    logic       kind_q, lp_q, from_stby_q;
    logic       pin_rise, light_wake, stby_wake;
    logic       tmr_load, tmr_done;
    logic [DLY_W-1:0] tmr_val;
    pgate_t     gates;

    pwr_sync #(.STAGES(SYNC_STGS)) u_pin (
        .clk(clk), .rst(rst), .d(wkpin_async), .en(wkpin_en), .rise(pin_rise)
    );

    pwr_wake_qual u_qual (
        .clk(clk), .rst(rst), .kind_evt(kind_q), .sev_on_pend(sev_on_pend),
        .irq_pending(irq_pending), .evt_in(evt_in), .pin_rise(pin_rise),
        .alarm_in(alarm_in), .ext_rst(ext_rst), .wdt_rst(wdt_rst),
        .light_wake(light_wake), .stby_wake(stby_wake)
    );

    pwr_wake_timer #(.W(DLY_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = dly_main;
        case (state_q)
            S_RUN: begin
                if (sleep_req)                       state_d = target_state(deep_sel, pdown_sel);
                else if (sleep_on_exit && handler_ret) state_d = S_SLEEP;
            end
            S_SLEEP: if (light_wake) state_d = S_RUN;
            S_STOP: begin
                if (light_wake) begin
                    state_d  = S_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = lp_q ? dly_lp : dly_main;
                end
            end
            S_STBY: begin
                if (stby_wake) begin
                    state_d  = S_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = dly_lp;
                end
            end
            S_WAKE:  if (tmr_done) state_d = S_RUN;
            default: state_d = S_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_RUN;
            kind_q      <= 1'b0;
            lp_q        <= 1'b0;
            from_stby_q <= 1'b0;
            restart     <= 1'b0;
            force_hsi   <= 1'b0;
        end else begin
            state_q   <= state_d;
            restart   <= (state_q == S_WAKE) && tmr_done &&  from_stby_q;
            force_hsi <= (state_q == S_WAKE) && tmr_done && !from_stby_q;
            if (state_q == S_RUN) begin
                if (sleep_req) begin
                    kind_q <= req_kind;
                    lp_q   <= lpreg_sel;
                end else if (sleep_on_exit && handler_ret) begin
                    kind_q <= 1'b0;
                end
            end
            if (state_q == S_STBY)      from_stby_q <= 1'b1;
            else if (state_q == S_STOP) from_stby_q <= 1'b0;
        end
    end

    assign gates         = gates_for(state_q, lp_q);
    assign cpu_clk_en    = gates.cpu_clk;
    assign periph_clk_en = gates.per_clk;
    assign osc_en        = gates.osc;
    assign reg_lp        = gates.reg_lp;
    assign core_pwr_en   = gates.core_pwr;

    always_comb begin
        case (state_q)
            S_SLEEP: mode_o = MODE_SLEEP;
            S_STOP:  mode_o = MODE_STOP;
            S_STBY:  mode_o = MODE_STBY;
            S_WAKE:  mode_o = from_stby_q ? MODE_STBY : MODE_STOP;
            default: mode_o = MODE_RUN;
        endcase
    end
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq_pending,
    input logic       evt_in,
    input logic       alarm_in,
    input logic       ext_rst,
    input logic       wdt_rst,
    input logic       wkpin_en,
    input logic       cpu_clk_en,
    input logic       periph_clk_en,
    input logic [2:0] osc_en,
    input logic       core_pwr_en,
    input logic       restart,
    input logic       force_hsi,
    input logic [1:0] mode_o
);
    p_run_gates_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0) |-> (cpu_clk_en && periph_clk_en && core_pwr_en));

    p_sleep_gates_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd1) |-> (!cpu_clk_en && periph_clk_en && osc_en == 3'b111));

    p_stop_gates_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |-> (!periph_clk_en && !cpu_clk_en && core_pwr_en));

    p_pwr_off_r4: assert property (@(posedge clk) disable iff (rst)
        !core_pwr_en |-> (mode_o == 2'd3 && osc_en == 3'b000));

    p_sleep_exit_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == 2'd1 && mode_o == 2'd0) |-> ($past(irq_pending) || $past(evt_in)));

    p_stby_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(core_pwr_en) && core_pwr_en) |->
        ($past(alarm_in) || $past(ext_rst) || $past(wdt_rst) || $past(wkpin_en)));

    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({restart, force_hsi}));

    p_pulse_once_r11: assert property (@(posedge clk) disable iff (rst)
        (restart || force_hsi) |=> (!restart && !force_hsi));

    p_pulse_in_run_r10: assert property (@(posedge clk) disable iff (rst)
        (restart || force_hsi) |-> (mode_o == 2'd0 && $past(osc_en) == 3'b001));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .irq_pending(irq_pending), .evt_in(evt_in),
    .alarm_in(alarm_in), .ext_rst(ext_rst), .wdt_rst(wdt_rst), .wkpin_en(wkpin_en),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .core_pwr_en(core_pwr_en), .restart(restart), .force_hsi(force_hsi), .mode_o(mode_o)
);

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst;
    logic sleep_req, req_kind, deep_sel, pdown_sel, lpreg_sel, sev_on_pend;
    logic sleep_on_exit, handler_ret, irq_pending, evt_in, wkpin_async, wkpin_en;
    logic alarm_in, ext_rst, wdt_rst;
    logic [DW-1:0] dly_main, dly_lp;
    logic cpu_clk_en, periph_clk_en, reg_lp, core_pwr_en, restart, force_hsi;
    logic [2:0] osc_en;
    logic [1:0] mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_seq_ctrl #(.DLY_W(DW)) u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .req_kind(req_kind),
        .deep_sel(deep_sel), .pdown_sel(pdown_sel), .lpreg_sel(lpreg_sel),
        .sev_on_pend(sev_on_pend), .sleep_on_exit(sleep_on_exit), .handler_ret(handler_ret),
        .irq_pending(irq_pending), .evt_in(evt_in), .wkpin_async(wkpin_async),
        .wkpin_en(wkpin_en), .alarm_in(alarm_in), .ext_rst(ext_rst), .wdt_rst(wdt_rst),
        .dly_main(dly_main), .dly_lp(dly_lp), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .osc_en(osc_en), .reg_lp(reg_lp),
        .core_pwr_en(core_pwr_en), .restart(restart), .force_hsi(force_hsi), .mode_o(mode_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_gates(input int mode, input logic lp);
        case (mode)
            1:       return 7'b0111101;
            2:       return {5'b00000, lp, 1'b1};
            3:       return 7'b0000000;
            default: return 7'b1111101;
        endcase
    endfunction

    function automatic int exp_cycles(input int mode, input logic lp, input int src,
                                      input int dm, input int dl);
        if (mode == 1) return 1;
        if (mode == 2) return (lp ? dl : dm) + 2;
        return (src == 2) ? dl + 4 : dl + 2;
    endfunction

    function automatic int act_gates();
        return {cpu_clk_en, periph_clk_en, osc_en, reg_lp, core_pwr_en};
    endfunction

    task automatic enter(input logic d, input logic p, input logic l, input logic k);
        deep_sel = d; pdown_sel = p; lpreg_sel = l; req_kind = k;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
    endtask

    task automatic wake(input int src, output int n);
        case (src)
            0: irq_pending = 1'b1;
            1: evt_in = 1'b1;
            2: wkpin_async = 1'b1;
            3: alarm_in = 1'b1;
            4: ext_rst = 1'b1;
            default: wdt_rst = 1'b1;
        endcase
        step();
        evt_in = 1'b0; ext_rst = 1'b0; wdt_rst = 1'b0;
        n = 1;
        while (mode_o != 2'd0 && n < 100) begin
            step();
            n++;
        end
    endtask

    task automatic settle();
        irq_pending = 1'b0; wkpin_async = 1'b0; alarm_in = 1'b0;
        repeat (4) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        rst = 1'b1;
        {sleep_req, req_kind, deep_sel, pdown_sel, lpreg_sel, sev_on_pend} = '0;
        {sleep_on_exit, handler_ret, irq_pending, evt_in, wkpin_async, wkpin_en} = '0;
        {alarm_in, ext_rst, wdt_rst} = '0;
        dly_main = 8'd3; dly_lp = 8'd9;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 mode", mode_o, 0);
        chk("R1 gates", act_gates(), exp_gates(0, 0));
        chk("R1 pulses", {restart, force_hsi}, 0);

        // R2 + R5: WFI sleep ignores event, wakes on irq
        enter(0, 0, 0, 0);
        chk("R2 mode", mode_o, 1);
        chk("R2 gates", act_gates(), exp_gates(1, 0));
        evt_in = 1'b1; step(); evt_in = 1'b0; step(); step();
        chk("R5 evt ignored", mode_o, 1);
        wake(0, n);
        chk("R5 irq exit cycles", n, 1);
        settle();

        // R6: WFE sleep ignores pending irq with sev_on_pend=0
        enter(0, 0, 0, 1);
        irq_pending = 1'b1; repeat (3) step();
        chk("R6 irq ignored", mode_o, 1);
        irq_pending = 1'b0; step();
        wake(1, n);
        chk("R6 evt exit cycles", n, 1);
        settle();

        // R7: already pending at entry does not wake; new pend does
        sev_on_pend = 1'b1;
        irq_pending = 1'b1; step();
        enter(0, 0, 0, 1);
        repeat (3) step();
        chk("R7 stale pend ignored", mode_o, 1);
        irq_pending = 1'b0; step();
        wake(0, n);
        chk("R7 new pend exit", n, 1);
        settle();
        sev_on_pend = 1'b0;

        // R3 + R10 + R11: Stop, low-power regulator
        enter(1, 0, 1, 0);
        chk("R3 mode", mode_o, 2);
        chk("R3 gates lp", act_gates(), exp_gates(2, 1));
        wake(0, n);
        chk("R10 stop lp delay", n, exp_cycles(2, 1, 0, 3, 9));
        chk("R11 force_hsi", force_hsi, 1);
        chk("R11 no restart", restart, 0);
        step();
        chk("R11 force_hsi single", force_hsi, 0);
        settle();

        // R4 + R8 + R9: Standby ignores irq/evt and disabled pin
        enter(1, 1, 0, 0);
        chk("R4 mode", mode_o, 3);
        chk("R4 gates", act_gates(), exp_gates(3, 0));
        irq_pending = 1'b1; evt_in = 1'b1; step(); evt_in = 1'b0;
        wkpin_async = 1'b1; repeat (5) step();
        chk("R8 irq/evt ignored", mode_o, 3);
        chk("R9 pin disabled ignored", mode_o, 3);
        irq_pending = 1'b0; wkpin_async = 1'b0; repeat (3) step();
        wkpin_en = 1'b1;
        wake(2, n);
        chk("R9 pin sync latency", n, exp_cycles(3, 0, 2, 3, 9));
        chk("R11 restart", restart, 1);
        chk("R11 no force_hsi", force_hsi, 0);
        settle();

        // R12 sleep-on-exit
        handler_ret = 1'b1; step(); handler_ret = 1'b0;
        chk("R12 ignored when off", mode_o, 0);
        sleep_on_exit = 1'b1;
        handler_ret = 1'b1; step(); handler_ret = 1'b0;
        chk("R12 reenter sleep", mode_o, 1);
        evt_in = 1'b1; step(); evt_in = 1'b0;
        chk("R12 wfi kind", mode_o, 1);
        wake(0, n);
        chk("R12 exit", n, 1);
        sleep_on_exit = 1'b0;
        settle();

        // Random mix
        for (int i = 0; i < 40; i++) begin
            int md, src, dm, dl;
            logic lp, k;
            md  = 1 + int'($urandom_range(0, 2));
            lp  = 1'($urandom_range(0, 1));
            k   = 1'($urandom_range(0, 1));
            dm  = int'($urandom_range(0, 5));
            dl  = int'($urandom_range(3, 12));
            sev_on_pend = 1'($urandom_range(0, 1));
            dly_main = DW'(dm); dly_lp = DW'(dl);
            src = (md == 3) ? 2 + int'($urandom_range(0, 3)) : (k ? 1 : 0);
            enter(md != 1, md == 3, lp, k);
            chk("R2 R3 R4 rand mode", mode_o, md);
            chk("R2 R3 R4 rand gates", act_gates(), exp_gates(md, lp));
            wake(src, n);
            chk("R10 rand delay", n, exp_cycles(md, lp, src, dm, dl));
            chk("R11 rand pulses", {restart, force_hsi},
                (md == 3) ? 2 : (md == 2) ? 1 : 0);
            settle();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule